// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Controller

This block sits beside a serial-bus link controller and turns eight link event pulses into a single interrupt vector. Each pulse sets a sticky pending flag. The flag with the highest priority is encoded into a byte that a CPU can use directly as an offset into a jump table. The byte is a multiple of four, so each table slot can hold a four-byte branch.

Reading the vector byte clears ordinary conditions at once. The three data-register conditions need a two-step handshake: a vector read arms the clear, and a later access to the link data register of the matching kind completes it. An end-of-transmission control bit also clears the transmit-empty condition. After software clears an invalid-symbol condition, the link stays held until an end-of-frame event arrives. A loopback enable isolates the block from all bus-originated events.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Event inputs map by bit of `ev_pulse` to codes as follows: bit0 end-of-frame = 1, bit1 in-frame-response byte = 2, bit2 receive-full = 3, bit3 transmit-empty = 4, bit4 arbitration lost = 5, bit5 CRC error = 6, bit6 invalid symbol = 7, bit7 wakeup = 8. Code 0 means nothing is pending, and a larger code has higher priority.
- R2: `vec_o` holds the code in bits [5:2], with bits [7:6] and [1:0] always zero. The reachable values are 0x00, 0x04 and so on up to 0x20. `vec_o` reflects a pulse from the clock edge that samples it.
- R3: When several flags are pending, `vec_o` reports only the highest-priority one.
- R4: A `vec_rd` strobe clears the reported flag when that flag is code 1, 5, 6, 7 or 8.
- R5: Receive-full (3) and in-frame-response (2) clear only on a `dat_rd` after an arming `vec_rd`. A `dat_rd` that is not armed has no effect, and a `dat_wr` never clears either flag.
- R6: Transmit-empty (4) clears on a `dat_wr` after an arming `vec_rd`, or in any cycle with `eot_set` high. A `dat_rd` never clears it.
- R7: A `vec_rd` that reports code 2, 3 or 4 arms the clear for that code. The arm is dropped by the first `dat_rd` or `dat_wr` after it, whether or not that access cleared anything, and it is replaced by the next `vec_rd`.
- R8: If a flag's event pulse arrives in the same cycle as that flag's clear, the flag stays pending.
- R9: When the invalid-symbol flag is actually cleared, `link_hold_o` rises on the next edge. It falls only after an accepted end-of-frame event. If the hold is set and an end-of-frame arrives in the same cycle, the hold wins.
- R10: While `loop_en` is high, all eight event inputs are ignored. No flag is set and no hold is released, and pending flags are kept.
- R11: `irq_o` is high exactly when `irq_en` is high and the reported code is nonzero.
- R12: After reset no flag is pending, no arm is held, `link_hold_o` is low and `vec_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_pulse | input | 8 | Single-cycle link event pulses, bit mapping per R1 |
| vec_rd | input | 1 | Read strobe of the vector byte |
| dat_rd | input | 1 | Read strobe of the link data register |
| dat_wr | input | 1 | Write strobe of the link data register |
| eot_set | input | 1 | End-of-transmission control bit |
| loop_en | input | 1 | Loopback enable; isolates bus events |
| irq_en | input | 1 | Global interrupt enable |
| vec_o | output | 8 | Vector byte of the highest pending source |
| irq_o | output | 1 | Interrupt request |
| link_hold_o | output | 1 | Receive and transmit held after an invalid-symbol clear |

## Verification
All 256 combinations of simultaneous event pulses are applied. Each combination is then drained by repeated vector reads, with the data access each code needs. This shows that priority order, code placement and the per-kind clear rules hold together, and the final hold state shows whether the invalid-symbol flag was among them. Directed sequences then separate the cases the sweep cannot. These are a data access with no arm, a data access of the wrong kind, an arm replaced or dropped, an event coinciding with its own clear, and end-of-frame events with and without loopback.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NSRC    = 8;
    localparam int CODE_W  = 4;
    localparam int VEC_W   = 8;
    localparam int VEC_LSB = 2;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE = 4'd0,
        SRC_EOF  = 4'd1,
        SRC_IFR  = 4'd2,
        SRC_RXF  = 4'd3,
        SRC_TXE  = 4'd4,
        SRC_ARB  = 4'd5,
        SRC_CRC  = 4'd6,
        SRC_SYM  = 4'd7,
        SRC_WAKE = 4'd8
    } src_code_e;

    typedef struct packed {
        logic [NSRC-1:0]   flag;
        logic              armed;
        logic [CODE_W-1:0] arm_code;
        logic              hold;
    } irqv_state_t;

    function automatic logic [NSRC-1:0] code2hot(input logic [CODE_W-1:0] c);
        logic [NSRC-1:0] hot;
        for (int i = 0; i < NSRC; i++) begin
            hot[i] = (c == CODE_W'(i + 1));
        end
        return hot;
    endfunction

    function automatic logic is_data_code(input logic [CODE_W-1:0] c);
        return (c == SRC_IFR) || (c == SRC_RXF) || (c == SRC_TXE);
    endfunction
endpackage

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
(
    input  logic [NSRC-1:0]   flags,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (flags[i]) begin
                code = CODE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irqv_flags.sv
module irqv_flags
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   ev_ok,
    input  logic              vec_rd,
    input  logic              dat_rd,
    input  logic              dat_wr,
    input  logic              eot_set,
    input  logic [CODE_W-1:0] cur_code,
    output logic [NSRC-1:0]   flag_q,
    output logic              hold_q
);
    irqv_state_t st_d, st_q;
    logic [NSRC-1:0] clr;
    logic            sym_gone;

    localparam int SYM_IDX = int'(SRC_SYM) - 1;
    localparam int EOF_IDX = int'(SRC_EOF) - 1;

    always_comb begin
        st_d = st_q;
        clr  = '0;

        // Second step of the handshake uses the arm held from earlier.
        if (st_q.armed && (dat_rd || dat_wr)) begin
            if (dat_rd && (st_q.arm_code == SRC_IFR || st_q.arm_code == SRC_RXF)) begin
                clr = clr | code2hot(st_q.arm_code);
            end
            if (dat_wr && st_q.arm_code == SRC_TXE) begin
                clr = clr | code2hot(st_q.arm_code);
            end
            st_d.armed = 1'b0;
        end

        // Vector read: clear ordinary flags, arm data-register flags.
        if (vec_rd) begin
            st_d.armed    = is_data_code(cur_code);
            st_d.arm_code = cur_code;
            if (!is_data_code(cur_code)) begin
                clr = clr | code2hot(cur_code);
            end
        end

        if (eot_set) begin
            clr = clr | code2hot(SRC_TXE);
        end

        // Set has precedence over clear.
        st_d.flag = ev_ok | (st_q.flag & ~clr);

        sym_gone = clr[SYM_IDX] && st_q.flag[SYM_IDX] && !ev_ok[SYM_IDX];
        if (sym_gone) begin
            st_d.hold = 1'b1;
        end else if (ev_ok[EOF_IDX]) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;
    assign hold_q = st_q.hold;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  ev_pulse,
    input  logic             vec_rd,
    input  logic             dat_rd,
    input  logic             dat_wr,
    input  logic             eot_set,
    input  logic             loop_en,
    input  logic             irq_en,
    output logic [VEC_W-1:0] vec_o,
    output logic             irq_o,
    output logic             link_hold_o
);
    logic [NSRC-1:0]   ev_ok;
    logic [NSRC-1:0]   flag_q;
    logic [CODE_W-1:0] cur_code;
    logic              hold_q;

    assign ev_ok = loop_en ? '0 : ev_pulse;

    irqv_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_ok    (ev_ok),
        .vec_rd   (vec_rd),
        .dat_rd   (dat_rd),
        .dat_wr   (dat_wr),
        .eot_set  (eot_set),
        .cur_code (cur_code),
        .flag_q   (flag_q),
        .hold_q   (hold_q)
    );

    irqv_prio u_prio (
        .flags (flag_q),
        .code  (cur_code)
    );

    assign vec_o       = VEC_W'(cur_code) << VEC_LSB;
    assign irq_o       = irq_en && (cur_code != SRC_NONE);
    assign link_hold_o = hold_q;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ev_pulse,
    input logic       vec_rd,
    input logic       dat_rd,
    input logic       dat_wr,
    input logic       eot_set,
    input logic       loop_en,
    input logic       irq_en,
    input logic [7:0] vec_o,
    input logic       irq_o,
    input logic       link_hold_o
);
    AST_STICKY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != 8'h00 && !vec_rd && !dat_rd && !dat_wr && !eot_set) |=> (vec_o != 8'h00)); // R4

    AST_DATA_FLAG_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && (vec_o == 8'h08 || vec_o == 8'h0C || vec_o == 8'h10) && !dat_rd && !dat_wr
         && !eot_set && ev_pulse == 8'h00) |=> (vec_o == $past(vec_o))); // R5

    AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse[7] && !loop_en) |=> (vec_o == 8'h20)); // R3

    AST_HOLD_ON_SYM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec_o == 8'h1C && !(ev_pulse[6] && !loop_en)) |=> link_hold_o); // R9

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_hold_o && ev_pulse[0] && !loop_en && !vec_rd) |=> !link_hold_o); // R9

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && vec_o == 8'h00) |=> (vec_o == 8'h00)); // R10

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en && vec_o != 8'h00)); // R11

    AST_IRQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && vec_o != 8'h00) |-> irq_o); // R11
endmodule

bind irq_vector_ctrl irqv_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_pulse    (ev_pulse),
    .vec_rd      (vec_rd),
    .dat_rd      (dat_rd),
    .dat_wr      (dat_wr),
    .eot_set     (eot_set),
    .loop_en     (loop_en),
    .irq_en      (irq_en),
    .vec_o       (vec_o),
    .irq_o       (irq_o),
    .link_hold_o (link_hold_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_pulse = 8'h00;
    logic       vec_rd = 1'b0;
    logic       dat_rd = 1'b0;
    logic       dat_wr = 1'b0;
    logic       eot_set = 1'b0;
    logic       loop_en = 1'b0;
    logic       irq_en = 1'b1;
    logic [7:0] vec_o;
    logic       irq_o;
    logic       link_hold_o;

    int n_tot = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [3:0] OP_NONE = 4'b0000;
    localparam logic [3:0] OP_VR   = 4'b1000;
    localparam logic [3:0] OP_DR   = 4'b0100;
    localparam logic [3:0] OP_DW   = 4'b0010;
    localparam logic [3:0] OP_EOT  = 4'b0001;

    always #2 clk = ~clk;

    irq_vector_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_pulse    (ev_pulse),
        .vec_rd      (vec_rd),
        .dat_rd      (dat_rd),
        .dat_wr      (dat_wr),
        .eot_set     (eot_set),
        .loop_en     (loop_en),
        .irq_en      (irq_en),
        .vec_o       (vec_o),
        .irq_o       (irq_o),
        .link_hold_o (link_hold_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives for one cycle, returns at the next falling edge.
    task automatic cyc(input logic [7:0] ev, input logic [3:0] op);
        ev_pulse = ev;
        {vec_rd, dat_rd, dat_wr, eot_set} = op;
        @(negedge clk);
        ev_pulse = 8'h00;
        {vec_rd, dat_rd, dat_wr, eot_set} = OP_NONE;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ev_pulse = 8'h00;
        {vec_rd, dat_rd, dat_wr, eot_set} = OP_NONE;
        loop_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] top_vec(input logic [7:0] pat);
        logic [7:0] v;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (pat[i]) v = 8'((i + 1) * 4);
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        do_reset();
        chk("R12 vec", vec_o, 8'h00);
        chk("R12 irq", {7'b0, irq_o}, 8'h00);
        chk("R12 hold", {7'b0, link_hold_o}, 8'h00);

        // Sweep all event combinations and drain them (R1, R2, R3, R4, R5, R6, R9, R11)
        for (int p = 0; p < 256; p++) begin
            do_reset();
            irq_en = p[0] ^ p[3];
            cyc(8'(p), OP_NONE);
            chk("R1/R2/R3 vec", vec_o, top_vec(8'(p)));
            chk("R11 irq", {7'b0, irq_o}, {7'b0, irq_en && (p != 0)});
            for (int c = 8; c >= 1; c--) begin
                if (p[c-1]) begin
                    chk("R3 drain order", vec_o, 8'(c * 4));
                    cyc(8'h00, OP_VR);
                    if (c == 2 || c == 3) cyc(8'h00, OP_DR);
                    if (c == 4) cyc(8'h00, OP_DW);
                end
            end
            chk("R4/R5/R6 drained", vec_o, 8'h00);
            chk("R9 hold after drain", {7'b0, link_hold_o}, {7'b0, p[6]});
        end
        irq_en = 1'b1;

        // R5: unarmed data read and wrong-kind write do not clear; R7 arm drops
        do_reset();
        cyc(8'h04, OP_NONE);
        cyc(8'h00, OP_DR);
        chk("R5 unarmed dat_rd", vec_o, 8'h0C);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_DW);
        chk("R5 dat_wr on rx-full", vec_o, 8'h0C);
        cyc(8'h00, OP_DR);
        chk("R7 arm dropped by access", vec_o, 8'h0C);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_DR);
        chk("R5 armed dat_rd", vec_o, 8'h00);

        // R7: arm replaced by next vector read, dat_rd on tx-empty arm drops it
        do_reset();
        cyc(8'h0C, OP_NONE);
        chk("R3 txe over rxf", vec_o, 8'h10);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_EOT);
        chk("R6 eot clears txe", vec_o, 8'h0C);
        cyc(8'h00, OP_DR);
        chk("R7 stale txe arm", vec_o, 8'h0C);
        cyc(8'h00, OP_DR);
        chk("R7 no arm left", vec_o, 8'h0C);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_DR);
        chk("R7 re-armed by vec_rd", vec_o, 8'h00);

        // R6: dat_rd never clears txe, armed dat_wr does
        do_reset();
        cyc(8'h08, OP_NONE);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_DR);
        chk("R6 dat_rd on txe", vec_o, 8'h10);
        cyc(8'h00, OP_VR);
        cyc(8'h00, OP_DW);
        chk("R6 armed dat_wr", vec_o, 8'h00);

        // R8: set wins over clear
        do_reset();
        cyc(8'h10, OP_NONE);
        cyc(8'h10, OP_VR);
        chk("R8 arb set vs read", vec_o, 8'h14);
        cyc(8'h00, OP_VR);
        chk("R4 arb cleared", vec_o, 8'h00);
        cyc(8'h04, OP_NONE);
        cyc(8'h00, OP_VR);
        cyc(8'h04, OP_DR);
        chk("R8 rxf set vs data clear", vec_o, 8'h0C);
        cyc(8'h08, OP_EOT);
        chk("R8 txe set vs eot", vec_o, 8'h10);

        // R9: hold behaviour
        do_reset();
        cyc(8'h40, OP_NONE);
        cyc(8'h40, OP_VR);
        chk("R8 sym kept", vec_o, 8'h1C);
        chk("R9 no hold if sym kept", {7'b0, link_hold_o}, 8'h00);
        cyc(8'h00, OP_VR);
        chk("R9 hold set", {7'b0, link_hold_o}, 8'h01);
        chk("R4 sym cleared", vec_o, 8'h00);
        cyc(8'h20, OP_NONE);
        chk("R9 crc keeps hold", {7'b0, link_hold_o}, 8'h01);
        cyc(8'h00, OP_VR);
        loop_en = 1'b1;
        cyc(8'h01, OP_NONE);
        chk("R10 looped eof ignored", {7'b0, link_hold_o}, 8'h01);
        loop_en = 1'b0;
        cyc(8'h01, OP_NONE);
        chk("R9 eof releases", {7'b0, link_hold_o}, 8'h00);
        chk("R1 eof code", vec_o, 8'h04);

        // R10: loopback ignores events, keeps pending
        do_reset();
        loop_en = 1'b1;
        cyc(8'hFF, OP_NONE);
        chk("R10 all ignored", vec_o, 8'h00);
        loop_en = 1'b0;
        cyc(8'h20, OP_NONE);
        loop_en = 1'b1;
        cyc(8'h80, OP_NONE);
        chk("R10 pending kept, wake ignored", vec_o, 8'h18);
        loop_en = 1'b0;

        // R11: enable gating
        irq_en = 1'b0;
        @(negedge clk);
        chk("R11 masked", {7'b0, irq_o}, 8'h00);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R11 unmasked", {7'b0, irq_o}, 8'h01);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule